// File: doc/BRIEF.md
# Table-Driven Multiplexed Acquisition Sequencer

This block paces a sixteen-input analog front end that shares one converter through two eight-way multiplexers. Before sampling starts, a host loads a configuration table through a plain write port. Each table word gives one sample's input channel, its amplifier gain code and whether the input is single-ended or differential. Once a non-zero pace divider is set, the sequencer takes one table word per sample period, in order. For each word it sets the shared multiplexer select lines, the two path switches and the gain lines. It waits a fixed settling interval and then asks the converter controller for one conversion.

Each finished conversion is written to a small first-word-fall-through FIFO. The FIFO word holds the table index next to the raw result, so software can apply the right gain and range to every code. After the last programmed index the walk returns to index 0. A zero divider stops sampling and moves the walk back to index 0. When the FIFO is full, the result is discarded and a sticky overflow flag is raised.

Top module: `acq_table_seq`

## Requirements
- R1: A table word has this layout: bits [3:0] hold the channel, bits [5:4] hold the gain code and bit 6 holds the differential flag. A word written through the write port controls the sample that uses that index.
- R2: For a single-ended word, `mux_sel` equals channel[2:0], `sw_pos_sel` equals channel[3] (0 selects mux A, 1 selects mux B) and `sw_neg_sel` is 0, which ties the negative path to ground.
- R3: For a differential word, `mux_sel` equals channel[2:0], `sw_pos_sel` is 0 and `sw_neg_sel` is 1, which pairs input k with input k+8. Channel bit 3 has no effect.
- R4: `gain_sel` carries the word's gain code: 0 selects x1, 1 selects x2, 2 selects x5 and 3 selects x10.
- R5: The routing and gain outputs change only at the start of a sample period. They stay unchanged while the sequencer settles and while it waits for the conversion.
- R6: `conv_req` rises exactly SETTLE_CYC cycles after the routing outputs update. It stays high until `conv_done` is seen and is low in the following cycle. A `conv_done` that arrives while no request is pending has no effect.
- R7: With `cfg_div` = D > 0, and with each conversion finishing inside its period, consecutive sample periods start D cycles apart.
- R8: While `cfg_div` is 0, no period starts and `conv_req` is low. A sample in progress is abandoned, and the next sample uses index 0.
- R9: Indices are used in order from 0 to `tbl_last`. The index after `tbl_last` is 0.
- R10: A FIFO word is {table index, 16-bit result}, with the index in the upper bits. `fifo_rdata` shows the oldest word. `fifo_rd` removes that word, and `fifo_rd` on an empty FIFO has no effect.
- R11: If a result arrives while the FIFO is full, the result is dropped and the stored words are kept. `fifo_ovf` goes high and stays high until reset. The table index still advances.
- R12: After reset, `conv_req` is low, all routing and gain outputs are 0, the FIFO is empty and `fifo_ovf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Sample period in clock cycles; 0 stops sampling |
| tbl_last | input | IDX_W | Highest table index in use |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | IDX_W | Table write index |
| tbl_wdata | input | 7 | Table word {diff, gain[1:0], chan[3:0]} |
| mux_sel | output | 3 | Shared select lines of both multiplexers |
| sw_pos_sel | output | 1 | Positive-path switch: 0 = mux A, 1 = mux B |
| sw_neg_sel | output | 1 | Negative-path switch: 0 = ground, 1 = mux B |
| gain_sel | output | 2 | Amplifier gain code |
| conv_req | output | 1 | Conversion request to the converter controller |
| conv_done | input | 1 | Conversion complete, result valid |
| conv_data | input | RES_W | Conversion result |
| fifo_rd | input | 1 | Remove the oldest FIFO word |
| fifo_rdata | output | IDX_W+RES_W | Oldest FIFO word {index, result} |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_ovf | output | 1 | Sticky flag: a result was dropped |

## Verification
A corrupted table index is visible at the FIFO output as soon as the next result is pushed. It also shows up within one period as routing outputs that do not match the expected table word. A wrong settle count or a wrong state appears at `conv_req` in the same sample period, either as a changed distance from the routing update to the request or as a request that is dropped or never raised. Counting faults in the pace divider or the FIFO show up at the next period boundary as a changed start-to-start distance. In the FIFO they show up as missing, repeated or reordered words, or as an early or missing overflow flag.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  localparam int ENTRY_W = 7;

  typedef struct packed {
    logic       diff;
    logic [1:0] gain;
    logic [3:0] chan;
  } tbl_entry_t;

  typedef struct packed {
    logic [2:0] mux_sel;
    logic       pos_b;
    logic       neg_b;
    logic [1:0] gain;
  } route_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_REQ    = 2'd2
  } seq_state_t;

  // Channel/mode to switch settings. Differential always puts mux A on the
  // positive path and mux B on the negative path; single-ended grounds the
  // negative path and lets channel bit 3 pick the positive source.
  function automatic route_t route_of(input tbl_entry_t e);
    route_t r;
    r.mux_sel = e.chan[2:0];
    r.gain    = e.gain;
    if (e.diff) begin
      r.pos_b = 1'b0;
      r.neg_b = 1'b1;
    end else begin
      r.pos_b = e.chan[3];
      r.neg_b = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/acq_pace_div.sv
module acq_pace_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             run;

  assign run  = (div != '0);
  assign tick = run && (cnt_q >= div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + DIV_W'(1);
  end

  // R7: with a period longer than one cycle, ticks never come back to back
  pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DIV_W'(1) && $stable(div)) |=> !tick);

endmodule

// File: rtl/acq_cfg_ram.sv
module acq_cfg_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    if (we && waddr == raddr)
      rdata <= wdata;
    else
      rdata <= mem[raddr];
  end

endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
  parameter int DATA_W   = 24,
  parameter int DEPTH_LG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic              ovf
);

  localparam int DEPTH = 1 << DEPTH_LG;

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [DEPTH_LG-1:0] wptr_q, rptr_q;
  logic [DEPTH_LG:0]   count_q;
  logic                wr_ok, rd_ok;

  assign empty = (count_q == '0);
  assign full  = (count_q == (DEPTH_LG+1)'(DEPTH));
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign dout  = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (wr_ok)
      mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf     <= 1'b0;
    end else begin
      if (wr_ok)
        wptr_q <= wptr_q + DEPTH_LG'(1);
      if (rd_ok)
        rptr_q <= rptr_q + DEPTH_LG'(1);
      case ({wr_ok, rd_ok})
        2'b10:   count_q <= count_q + (DEPTH_LG+1)'(1);
        2'b01:   count_q <= count_q - (DEPTH_LG+1)'(1);
        default: count_q <= count_q;
      endcase
      if (push && full)
        ovf <= 1'b1;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (ovf && full));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= (DEPTH_LG+1)'(DEPTH));

endmodule

// File: rtl/acq_table_seq.sv
module acq_table_seq
  import acq_seq_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int DIV_W      = 16,
  parameter int RES_W      = 16,
  parameter int SETTLE_CYC = 192,
  parameter int FIFO_LG    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DIV_W-1:0]       cfg_div,
  input  logic [IDX_W-1:0]       tbl_last,
  input  logic                   tbl_we,
  input  logic [IDX_W-1:0]       tbl_waddr,
  input  logic [ENTRY_W-1:0]     tbl_wdata,
  output logic [2:0]             mux_sel,
  output logic                   sw_pos_sel,
  output logic                   sw_neg_sel,
  output logic [1:0]             gain_sel,
  output logic                   conv_req,
  input  logic                   conv_done,
  input  logic [RES_W-1:0]       conv_data,
  input  logic                   fifo_rd,
  output logic [IDX_W+RES_W-1:0] fifo_rdata,
  output logic                   fifo_empty,
  output logic                   fifo_full,
  output logic                   fifo_ovf
);

  localparam int                SET_W    = $clog2(SETTLE_CYC + 1);
  localparam int                WORD_W   = IDX_W + RES_W;
  localparam logic [SET_W-1:0]  SET_LOAD = SET_W'(SETTLE_CYC - 1);

  function automatic logic [IDX_W-1:0] idx_advance(
    input logic [IDX_W-1:0] cur,
    input logic [IDX_W-1:0] last
  );
    return (cur >= last) ? '0 : cur + IDX_W'(1);
  endfunction

  seq_state_t         st_q;
  logic [SET_W-1:0]   settle_q;
  logic [IDX_W-1:0]   idx_q, idx_d;
  route_t             route_q;
  logic [ENTRY_W-1:0] rd_raw;
  tbl_entry_t         rd_entry;
  logic               seq_on, pace_tick;
  logic               evt_start, evt_settled, evt_end;
  logic [WORD_W-1:0]  push_word;

  assign seq_on      = (cfg_div != '0);
  assign evt_start   = seq_on && (st_q == SQ_IDLE) && pace_tick;
  assign evt_settled = seq_on && (st_q == SQ_SETTLE) && (settle_q == '0);
  assign evt_end     = seq_on && (st_q == SQ_REQ) && conv_done;
  assign rd_entry    = tbl_entry_t'(rd_raw);
  assign push_word   = {idx_q, conv_data};

  always_comb begin
    if (!seq_on)
      idx_d = '0;
    else if (evt_end)
      idx_d = idx_advance(idx_q, tbl_last);
    else
      idx_d = idx_q;
  end

  acq_pace_div #(.DIV_W(DIV_W)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (cfg_div),
    .tick  (pace_tick)
  );

  acq_cfg_ram #(.ADDR_W(IDX_W), .DATA_W(ENTRY_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (idx_d),
    .rdata (rd_raw)
  );

  acq_sample_fifo #(.DATA_W(WORD_W), .DEPTH_LG(FIFO_LG)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (evt_end),
    .din   (push_word),
    .pop   (fifo_rd),
    .dout  (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full),
    .ovf   (fifo_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      settle_q <= '0;
      idx_q    <= '0;
      route_q  <= '0;
    end else begin
      idx_q <= idx_d;
      if (!seq_on) begin
        st_q     <= SQ_IDLE;
        settle_q <= '0;
      end else begin
        case (st_q)
          SQ_IDLE: if (pace_tick) begin
            route_q  <= route_of(rd_entry);
            settle_q <= SET_LOAD;
            st_q     <= SQ_SETTLE;
          end
          SQ_SETTLE: begin
            if (evt_settled)
              st_q <= SQ_REQ;
            else
              settle_q <= settle_q - SET_W'(1);
          end
          SQ_REQ: if (conv_done)
            st_q <= SQ_IDLE;
          default: st_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign conv_req   = (st_q == SQ_REQ);
  assign mux_sel    = route_q.mux_sel;
  assign sw_pos_sel = route_q.pos_b;
  assign sw_neg_sel = route_q.neg_b;
  assign gain_sel   = route_q.gain;

  // Checker-side count of cycles since the last period start.
  logic [SET_W:0] chk_since;
  always_ff @(posedge clk) begin
    if (!rst_n)
      chk_since <= '0;
    else if (evt_start)
      chk_since <= '0;
    else if (chk_since != '1)
      chk_since <= chk_since + (SET_W+1)'(1);
  end

  // R6
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> (chk_since == (SET_W+1)'(SETTLE_CYC)));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && seq_on) |=> conv_req);

  // R5
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> ($stable(mux_sel) && $stable(gain_sel)
                                  && $stable(sw_pos_sel) && $stable(sw_neg_sel)));

  // R8
  div_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div == '0) |=> !conv_req);

  // R9
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && idx_q >= tbl_last) |=> (idx_q == '0));

  // R3
  diff_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_neg_sel |-> !sw_pos_sel);

endmodule

// File: tb/tb_acq_table_seq.sv
`timescale 1ns/1ps
module tb_acq_table_seq;

  localparam int IDX_W  = 4;
  localparam int DIV_W  = 16;
  localparam int RES_W  = 16;
  localparam int SETTLE = 12;
  localparam int FLG    = 2;
  localparam int PERIOD = 40;
  localparam int NVEC   = 6;

  // {entry[6:0], mux[2:0], pos, neg, gain[1:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {7'h03, 3'd3, 1'b0, 1'b0, 2'd0},
    {7'h2C, 3'd4, 1'b1, 1'b0, 2'd2},
    {7'h55, 3'd5, 1'b0, 1'b1, 2'd1},
    {7'h7E, 3'd6, 1'b0, 1'b1, 2'd3},
    {7'h38, 3'd0, 1'b1, 1'b0, 2'd3},
    {7'h10, 3'd0, 1'b0, 1'b0, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [IDX_W-1:0] tbl_last = '0, tbl_waddr = '0;
  logic tbl_we = 1'b0;
  logic [6:0] tbl_wdata = '0;
  logic [2:0] mux_sel;
  logic sw_pos_sel, sw_neg_sel, conv_req, fifo_empty, fifo_full, fifo_ovf;
  logic [1:0] gain_sel;
  logic conv_done = 1'b0, fifo_rd = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic [IDX_W+RES_W-1:0] fifo_rdata;

  acq_table_seq #(.IDX_W(IDX_W), .DIV_W(DIV_W), .RES_W(RES_W),
                  .SETTLE_CYC(SETTLE), .FIFO_LG(FLG)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .tbl_last(tbl_last),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .mux_sel(mux_sel), .sw_pos_sel(sw_pos_sel), .sw_neg_sel(sw_neg_sel),
    .gain_sel(gain_sel), .conv_req(conv_req), .conv_done(conv_done),
    .conv_data(conv_data), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_ovf(fifo_ovf));

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int cyc = 0, chg_cyc = 0, chg_cnt = 0, prev_start = 0;
  bit have_prev = 0;
  logic [6:0] route_prev = '0;
  logic [IDX_W+RES_W-1:0] saved [4];
  int smp_no = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if ({mux_sel, sw_pos_sel, sw_neg_sel, gain_sel} != route_prev) begin
      chg_cyc = cyc;
      chg_cnt = chg_cnt + 1;
    end
    route_prev = {mux_sel, sw_pos_sel, sw_neg_sel, gain_sel};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic wait_req(output bit got);
    got = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (conv_req) begin
        got = 1;
        return;
      end
    end
  endtask

  task automatic pop_check(input logic [IDX_W+RES_W-1:0] exp, input string req);
    check(!fifo_empty && fifo_rdata == exp, req, "fifo word", fifo_rdata, exp);
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  // Serve one sample that should use table index vi.
  task automatic run_sample(input int vi, input bit pop_now, input bit push_ok,
                            input bit chk_period, output logic [IDX_W+RES_W-1:0] word);
    bit got;
    logic [6:0] r0;
    logic [RES_W-1:0] d;
    string rq;
    wait_req(got);
    check(got, "R6", "request raised", got, 1);
    word = '0;
    if (!got) return;
    check(cyc - chg_cyc == SETTLE, "R6", "settle cycles", cyc - chg_cyc, SETTLE);
    if (chk_period && have_prev)
      check(chg_cyc - prev_start == PERIOD, "R7", "period", chg_cyc - prev_start, PERIOD);
    prev_start = chg_cyc;
    have_prev = 1;
    rq = VEC[vi][13] ? "R1 R3" : "R1 R2";
    check(mux_sel == VEC[vi][6:4], rq, "mux_sel", mux_sel, VEC[vi][6:4]);
    check({sw_pos_sel, sw_neg_sel} == VEC[vi][3:2], rq, "switches",
          {sw_pos_sel, sw_neg_sel}, VEC[vi][3:2]);
    check(gain_sel == VEC[vi][1:0], "R4", "gain_sel", gain_sel, VEC[vi][1:0]);
    r0 = {mux_sel, sw_pos_sel, sw_neg_sel, gain_sel};
    repeat (3) @(negedge clk);
    check(conv_req && r0 == {mux_sel, sw_pos_sel, sw_neg_sel, gain_sel}, "R5",
          "hold while waiting", {conv_req, mux_sel, sw_pos_sel, sw_neg_sel, gain_sel},
          {1'b1, r0});
    if (!push_ok)
      check(fifo_full, "R11", "full before drop", fifo_full, 1);
    smp_no++;
    d = RES_W'(16'h5A00 + smp_no * 16'h0107);
    word = {IDX_W'(vi), d};
    conv_done = 1'b1;
    conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
    check(!conv_req, "R6", "request dropped", conv_req, 0);
    if (pop_now)
      pop_check(word, "R9 R10");
  endtask

  initial begin
    #750000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [IDX_W+RES_W-1:0] w;
    int hi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    check(!conv_req, "R12", "conv_req", conv_req, 0);
    check({mux_sel, sw_pos_sel, sw_neg_sel, gain_sel} == 7'd0, "R12", "route",
          {mux_sel, sw_pos_sel, sw_neg_sel, gain_sel}, 0);
    check(fifo_empty && !fifo_full, "R12", "fifo empty", {fifo_empty, fifo_full}, 2'b10);
    check(!fifo_ovf, "R12", "ovf", fifo_ovf, 0);

    for (int i = 0; i < NVEC; i++) begin
      tbl_we = 1'b1;
      tbl_waddr = IDX_W'(i);
      tbl_wdata = VEC[i][13:7];
      @(negedge clk);
    end
    tbl_we = 1'b0;
    tbl_last = IDX_W'(NVEC - 1);

    // R8: divider zero keeps sampling off
    hi = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (conv_req) hi++;
    end
    check(hi == 0, "R8", "requests while off", hi, 0);

    // Main walk through the table, wrapping past tbl_last (R9)
    cfg_div = DIV_W'(PERIOD);
    for (int s = 0; s < 8; s++)
      run_sample(s % NVEC, 1'b1, 1'b1, 1'b1, w);

    // R6: stray done while idle is ignored
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check(fifo_empty && !conv_req, "R6", "stray done", {fifo_empty, conv_req}, 2'b10);
    // R10: pop on empty has no effect
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
    check(fifo_empty && !fifo_full, "R10", "pop empty", {fifo_empty, fifo_full}, 2'b10);

    // R11: fill the FIFO, then one more sample is dropped
    for (int s = 0; s < 4; s++) begin
      run_sample((8 + s) % NVEC, 1'b0, 1'b1, 1'b1, w);
      saved[s] = w;
    end
    run_sample(0, 1'b0, 1'b0, 1'b1, w);
    check(fifo_ovf, "R11", "ovf set", fifo_ovf, 1);
    check(fifo_full, "R11", "still full", fifo_full, 1);
    for (int s = 0; s < 4; s++)
      pop_check(saved[s], "R11");
    check(fifo_empty, "R11", "dropped word absent", fifo_empty, 1);
    check(fifo_ovf, "R11", "ovf sticky", fifo_ovf, 1);

    // R8: abandon a sample in flight (index 1), restart at index 0
    begin
      bit got;
      wait_req(got);
      check(got && mux_sel == VEC[1][6:4], "R11", "index advanced past drop",
            mux_sel, VEC[1][6:4]);
    end
    cfg_div = '0;
    hi = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (conv_req) hi++;
    end
    check(hi == 0, "R8", "no request after stop", hi, 0);
    check(fifo_empty, "R8", "no push after stop", fifo_empty, 1);
    cfg_div = DIV_W'(PERIOD);
    have_prev = 0;
    run_sample(0, 1'b1, 1'b1, 1'b0, w);
    run_sample(1, 1'b1, 1'b1, 1'b1, w);

    summary();
  end

endmodule